// File: doc/BRIEF.md
# Watchdog and Power-Down Supervisor

This block governs three supply-side controls of a host system: the active-low CPU reset line, the power-supply enable and the clock-output enable. A fourth output gates the serial port. It contains a watchdog and a software power-down controller. The watchdog counts periodic reference ticks. The host restarts it by opening and closing slave select with no data moved during that select cycle. If the host stops doing this, the block first waits a short grace period and then pulses the CPU reset. It also raises a sticky status flag.

Software power-down is requested by a one-cycle set pulse from the control register. It pulls the reset, the supply enable, the clock enable and the serial-port enable low together. The condition holds until system power shows a rising edge, or until an enabled interrupt arrives while system power is present. On wake-up all four outputs return high and the watchdog starts a fresh window.

Top module: `wdog_pwr_supervisor`

## Requirements
- R1: After reset, `cpu_rst_n`, `pse`, `clk_en` and `spi_en` are 1 and `wd_flag` is 0.
- R2: A select cycle (`sel_n` low, then high) during which `xfer_active` was never 1 restarts the watchdog window. The restart happens on the cycle in which `sel_n` returns high.
- R3: A select cycle during which `xfer_active` was 1 on any cycle with `sel_n` low does not restart the window.
- R4: The window is `BASE_TICKS << win_sel` reference ticks. With defaults, `win_sel` = 0, 1, 2, 3 gives 4, 8, 16, 32 ticks.
- R5: Once the window has elapsed, `cpu_rst_n` goes low on the `DELAY_TICKS`-th further tick (default 2). It stays low for `PULSE_TICKS` ticks (default 3), after which a new window begins.
- R6: `wd_flag` is set when the watchdog reset pulse starts. It stays set until a `stat_rd` pulse clears it.
- R7: While `wd_en` is 0, the watchdog never issues a reset and its count is cleared.
- R8: A `pd_set` pulse drives `cpu_rst_n`, `pse`, `clk_en` and `spi_en` low from the next cycle.
- R9: While powered down, a rising edge on `sys_pwr` wakes the block, and all four outputs return to 1.
- R10: While powered down, `irq_event` wakes the block only if `sys_pwr` is 1. With `sys_pwr` at 0 it has no effect.
- R11: While powered down, the watchdog is held: select toggles and ticks neither start a reset nor set `wd_flag`. After wake-up a full window is counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick pulse |
| sel_n | input | 1 | Slave select, active low, synchronous to clk |
| xfer_active | input | 1 | High on cycles where a serial data bit moves |
| wd_en | input | 1 | Watchdog enable control bit |
| win_sel | input | 2 | Watchdog window length select |
| stat_rd | input | 1 | Status read pulse, clears wd_flag |
| pd_set | input | 1 | One-cycle software power-down request |
| irq_event | input | 1 | Enabled alarm, periodic or power-sense interrupt |
| sys_pwr | input | 1 | System power present level |
| cpu_rst_n | output | 1 | CPU reset, active low |
| pse | output | 1 | Power-supply enable |
| clk_en | output | 1 | Clock-output enable |
| spi_en | output | 1 | Serial interface enable |
| wd_flag | output | 1 | Sticky watchdog-expired status |

## Verification
The assertions assume that `sel_n`, `xfer_active`, `sys_pwr` and `irq_event` are already synchronous to `clk`. They also assume that `pd_set`, `stat_rd` and `ref_tick` are single-cycle pulses. The stimulus drives every input on the falling clock edge and pulses those three strobes for exactly one cycle. Ticks are spaced at least one idle cycle apart, so each tick is counted once. `win_sel` is changed only while the watchdog is disabled, which keeps the count below the selected limit.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    PH_WATCH = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2
  } wd_phase_t;

  // window length in ticks for a given select code
  function automatic int unsigned window_ticks(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/sel_kick_det.sv
module sel_kick_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic xfer_active,
  input  logic gate_off,
  output logic kick
);
  logic sel_q;
  logic xfer_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b1;
      xfer_seen <= 1'b0;
    end else begin
      sel_q <= sel_n;
      if (!sel_n && xfer_active) xfer_seen <= 1'b1;
      else if (sel_n)            xfer_seen <= 1'b0;
    end
  end

  assign kick = sel_n && !sel_q && !xfer_seen && !gate_off;

  // R2: a kick is always the closing edge of a select cycle
  a_r2_kick_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !$past(sel_n));
  // R3: data moved under select forbids a kick on the following cycle
  a_r3_xfer_blocks_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && xfer_active) |=> !kick);
endmodule

// File: rtl/wd_timer.sv
module wd_timer
  import wdsup_pkg::*;
#(
  parameter int unsigned BASE_TICKS  = 4,
  parameter int unsigned DELAY_TICKS = 2,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       kick,
  input  logic [1:0] win_sel,
  input  logic       stat_rd,
  output logic       wd_pulse,
  output logic       wd_flag
);
  localparam int unsigned MAX_WIN = BASE_TICKS << 3;
  localparam int unsigned MAX_A   = (MAX_WIN > DELAY_TICKS) ? MAX_WIN : DELAY_TICKS;
  localparam int unsigned MAX_CNT = (MAX_A > PULSE_TICKS) ? MAX_A : PULSE_TICKS;
  localparam int unsigned CW      = $clog2(MAX_CNT + 1);

  wd_phase_t     phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] limit;
  logic          timeout_evt;

  assign cnt_nx      = cnt + CW'(1);
  assign limit       = CW'(window_ticks(BASE_TICKS, win_sel));
  assign timeout_evt = enable && (phase == PH_DELAY) && tick && (cnt_nx >= CW'(DELAY_TICKS));
  assign wd_pulse    = (phase == PH_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WATCH;
      cnt   <= '0;
    end else if (!enable) begin
      phase <= PH_WATCH;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_WATCH: begin
          if (kick) cnt <= '0;
          else if (tick) begin
            if (cnt_nx >= limit) begin
              phase <= PH_DELAY;
              cnt   <= '0;
            end else cnt <= cnt_nx;
          end
        end
        PH_DELAY: begin
          if (timeout_evt) begin
            phase <= PH_PULSE;
            cnt   <= '0;
          end else if (tick) cnt <= cnt_nx;
        end
        default: begin
          if (tick) begin
            if (cnt_nx >= CW'(PULSE_TICKS)) begin
              phase <= PH_WATCH;
              cnt   <= '0;
            end else cnt <= cnt_nx;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wd_flag <= 1'b0;
    else if (timeout_evt) wd_flag <= 1'b1;
    else if (stat_rd)     wd_flag <= 1'b0;
  end

  // R5: the reset pulse only begins out of the grace period
  a_r5_pulse_from_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_pulse) |-> $past(phase) == PH_DELAY);
  // R6: the flag is raised as the pulse starts
  a_r6_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (wd_flag && wd_pulse));
  // R6: the flag stays set until a status read
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !stat_rd) |=> wd_flag);
  // R7: a disabled watchdog issues no reset
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wd_pulse);
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_set,
  input  logic sys_pwr,
  input  logic irq_event,
  output logic pd_active
);
  logic sys_q;
  logic wake_evt;

  assign wake_evt = pd_active && sys_pwr && (!sys_q || irq_event);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q     <= 1'b0;
      pd_active <= 1'b0;
    end else begin
      sys_q <= sys_pwr;
      if (pd_active) begin
        if (wake_evt) pd_active <= 1'b0;
      end else if (pd_set) pd_active <= 1'b1;
    end
  end

  // R8: a request while running always enters power-down
  a_r8_enter_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_set && !pd_active) |=> pd_active);
  // R10: no wake-up without system power
  a_r10_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !sys_pwr) |=> pd_active);
  // R9, R10: a wake event leaves power-down
  a_r9_wake_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !pd_active);
endmodule

// File: rtl/wdog_pwr_supervisor.sv
module wdog_pwr_supervisor #(
  parameter int unsigned BASE_TICKS  = 4,
  parameter int unsigned DELAY_TICKS = 2,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       sel_n,
  input  logic       xfer_active,
  input  logic       wd_en,
  input  logic [1:0] win_sel,
  input  logic       stat_rd,
  input  logic       pd_set,
  input  logic       irq_event,
  input  logic       sys_pwr,
  output logic       cpu_rst_n,
  output logic       pse,
  output logic       clk_en,
  output logic       spi_en,
  output logic       wd_flag
);
  logic pd_active;
  logic kick;
  logic wd_pulse;
  logic wd_run;

  assign wd_run = wd_en && !pd_active;

  sel_kick_det u_kick (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_active(xfer_active),
    .gate_off(pd_active), .kick(kick)
  );

  wd_timer #(
    .BASE_TICKS(BASE_TICKS), .DELAY_TICKS(DELAY_TICKS), .PULSE_TICKS(PULSE_TICKS)
  ) u_wd (
    .clk(clk), .rst_n(rst_n), .enable(wd_run), .tick(ref_tick), .kick(kick),
    .win_sel(win_sel), .stat_rd(stat_rd), .wd_pulse(wd_pulse), .wd_flag(wd_flag)
  );

  pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n), .pd_set(pd_set), .sys_pwr(sys_pwr),
    .irq_event(irq_event), .pd_active(pd_active)
  );

  assign cpu_rst_n = !(pd_active || wd_pulse);
  assign pse       = !pd_active;
  assign clk_en    = !pd_active;
  assign spi_en    = !pd_active;

  // R11: power-down stops the watchdog pulse
  a_r11_wd_held_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> !wd_pulse);
  // R8: supply, clock and port enables move together
  a_r8_outputs_together: assert property (@(posedge clk) disable iff (!rst_n)
    (pse == clk_en) && (pse == spi_en) && (!pse -> !cpu_rst_n));
endmodule

// File: tb/tb_wdog_pwr_supervisor.sv
module tb_wdog_pwr_supervisor;
  logic clk = 0, rst_n = 0;
  logic ref_tick = 0, sel_n = 1, xfer_active = 0, wd_en = 0;
  logic [1:0] win_sel = 0;
  logic stat_rd = 0, pd_set = 0, irq_event = 0, sys_pwr = 1;
  logic cpu_rst_n, pse, clk_en, spi_en, wd_flag;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wdog_pwr_supervisor dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sel_n(sel_n),
    .xfer_active(xfer_active), .wd_en(wd_en), .win_sel(win_sel), .stat_rd(stat_rd),
    .pd_set(pd_set), .irq_event(irq_event), .sys_pwr(sys_pwr),
    .cpu_rst_n(cpu_rst_n), .pse(pse), .clk_en(clk_en), .spi_en(spi_en), .wd_flag(wd_flag)
  );

  typedef struct packed { logic [1:0] sel; logic [7:0] n; logic exp_rst_n; } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd3, 1'b1}, '{2'd0, 8'd5, 1'b1}, '{2'd0, 8'd6, 1'b0},
    '{2'd0, 8'd8, 1'b0}, '{2'd0, 8'd9, 1'b1}, '{2'd1, 8'd9, 1'b1},
    '{2'd1, 8'd10, 1'b0}, '{2'd2, 8'd17, 1'b1}, '{2'd2, 8'd18, 1'b0},
    '{2'd3, 8'd33, 1'b1}, '{2'd3, 8'd34, 1'b0}, '{2'd3, 8'd37, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic tick(); ref_tick = 1; cyc(); ref_tick = 0; cyc(); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic kick(); sel_n = 0; cyc(); cyc(); sel_n = 1; cyc(); endtask
  task automatic xfer_kick();
    sel_n = 0; cyc(); xfer_active = 1; cyc(); xfer_active = 0; cyc(); sel_n = 1; cyc();
  endtask
  task automatic restart_wd(input logic [1:0] s);
    wd_en = 0; cyc(); win_sel = s; wd_en = 1; kick();
  endtask
  task automatic pulse_rd(); stat_rd = 1; cyc(); stat_rd = 0; cyc(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1 cpu_rst_n", cpu_rst_n, 1'b1);
    chk("R1 pse", pse, 1'b1);
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 spi_en", spi_en, 1'b1);
    chk("R1 wd_flag", wd_flag, 1'b0);

    // R4 R5 window lengths, grace period and pulse width
    for (int v = 0; v < NV; v++) begin
      restart_wd(VECS[v].sel);
      ticks(int'(VECS[v].n));
      chk($sformatf("R4/R5 sel=%0d n=%0d", VECS[v].sel, VECS[v].n), cpu_rst_n, VECS[v].exp_rst_n);
    end

    // R6 flag sticky then cleared by read
    wd_en = 0; repeat (10) cyc();
    chk("R6 flag held", wd_flag, 1'b1);
    pulse_rd();
    chk("R6 flag cleared", wd_flag, 1'b0);

    // R2 clean select cycle restarts the window
    restart_wd(2'd0); ticks(3); kick(); ticks(3);
    chk("R2 clean kick", cpu_rst_n, 1'b1);
    chk("R2 no flag", wd_flag, 1'b0);

    // R3 select with transfer does not restart
    restart_wd(2'd0); ticks(3); xfer_kick(); ticks(3);
    chk("R3 xfer select ignored", cpu_rst_n, 1'b0);

    // R7 disabled watchdog
    wd_en = 0; cyc(); pulse_rd(); ticks(40);
    chk("R7 no reset", cpu_rst_n, 1'b1);
    chk("R7 no flag", wd_flag, 1'b0);

    // R8 software power-down
    restart_wd(2'd0);
    pd_set = 1; cyc(); pd_set = 0;
    chk("R8 cpu_rst_n", cpu_rst_n, 1'b0);
    chk("R8 pse", pse, 1'b0);
    chk("R8 clk_en", clk_en, 1'b0);
    chk("R8 spi_en", spi_en, 1'b0);

    // R11 watchdog held while down
    for (int i = 0; i < 10; i++) begin ticks(4); kick(); end
    chk("R11 no flag in pd", wd_flag, 1'b0);

    // R10 interrupt without power is ignored
    sys_pwr = 0; cyc(); irq_event = 1; cyc(); irq_event = 0; cyc();
    chk("R10 irq without power", clk_en, 1'b0);

    // R9 supply rising edge wakes
    sys_pwr = 1; cyc(); cyc();
    chk("R9 pse up", pse, 1'b1);
    chk("R9 cpu_rst_n up", cpu_rst_n, 1'b1);
    chk("R9 spi_en up", spi_en, 1'b1);

    // R11 fresh window after wake
    ticks(3);
    chk("R11 fresh window", cpu_rst_n, 1'b1);
    ticks(3);
    chk("R11 window still counts", cpu_rst_n, 1'b0);

    // R10 interrupt with power present wakes
    wd_en = 0; cyc();
    pd_set = 1; cyc(); pd_set = 0; cyc();
    chk("R10 down again", pse, 1'b0);
    irq_event = 1; cyc(); irq_event = 0; cyc();
    chk("R10 irq wakes", pse, 1'b1);
    chk("R10 clk_en up", clk_en, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule